// File: doc/BRIEF.md
# Pipelined Converter Code Combiner

This block sits behind a seven-stage pipelined analog-to-digital converter and turns the raw stage decisions into one 14-bit sample. Six coarse stages each report a 3-bit decision, and a final stage reports a 2-bit decision. Each coarse decision carries two effective bits plus one redundant bit. The redundant bit overlaps the next stage's range, so a comparator error in one stage is corrected by the stages after it.

The stages resolve one after another. The decision for stage k of a sample reaches the block k cycles after the cycle in which that sample's strobe was raised. The block delays each stage's decision so that all seven decisions of one sample meet in the same cycle. It then adds them at overlapping binary weights, saturates the sum to the 14-bit range, and can optionally convert the result to two's-complement form. A new sample may start on every clock cycle. Because the analog path has no states of its own, the design is a fixed pipeline rather than a state machine. Its only enumerated type is the output number format.

Top module: `adc_pipe_corrector`

## Requirements
- R1: While reset is asserted and after it is released, before any sample completes, `dout` reads 0 and `dout_vld` reads 0.
- R2: `dout_vld` is high in the eighth cycle after each cycle in which `sample_vld` was high, once per strobe, and it is low in every other cycle.
- R3: For a sample strobed in cycle t, the decision of coarse stage k (k = 1..6) is taken from bits `stage_codes[3k-1:3k-3]` in cycle t+k, and the final-stage decision is taken from `last_code` in cycle t+7. Values present on those inputs in any other cycle do not change that sample's result.
- R4: In offset-binary format, the result is d1·2^11 + d2·2^9 + d3·2^7 + d4·2^5 + d5·2^3 + d6·2^1 + d7, where d1..d6 are the coarse decisions (0 to 7) and d7 is the final decision (0 to 3).
- R5: When the sum of R4 exceeds 16383, the result is 16383.
- R6: If `twos_fmt` is high in cycle t+7, which is the cycle in which the final-stage decision is presented, the result has bit 13 inverted (offset binary to two's complement). If it is low, the result is left unchanged.
- R7: Samples strobed in consecutive cycles each produce their own correct result in consecutive cycles.
- R8: While `dout_vld` is low, `dout` keeps the last result it delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | Strobe marking the cycle a new sample is taken |
| stage_codes | input | 18 | Coarse stage decisions, 3 bits per stage, stage 1 in the low bits |
| last_code | input | 2 | Final stage decision |
| twos_fmt | input | 1 | Selects two's-complement output for the sample completing this cycle |
| dout | output | 14 | Corrected sample |
| dout_vld | output | 1 | Marks a cycle carrying a new corrected sample |

## Verification
The bench builds the block with its default parameters: six 3-bit stages and a 2-bit last stage. At this size every decision value of every stage can be swept one at a time, and the bench computes each expected word arithmetically from the weights. With these parameters the saturation boundary sits at a reachable pattern, so the exact-full-scale case and the first overflowing case are both driven. The bench also drives noise on every stage input outside the cycle in which that stage's decision is due, interleaves back-to-back and gapped strobes, and toggles the format input per sample.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    typedef enum logic {
        FMT_OFFSET = 1'b0,
        FMT_TWOS   = 1'b1
    } out_fmt_e;

    // Bit position at which the decision of stage k (1-based) is added.
    function automatic int stage_shift(input int k, input int n_full,
                                       input int full_w, input int last_w);
        return (n_full - k) * (full_w - 1) + (last_w - 1);
    endfunction

endpackage

// File: rtl/code_align.sv
module code_align #(
    parameter int W     = 3,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign q = d;
        end else begin : g_delay
            logic [W-1:0] taps [DEPTH];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
                end else begin
                    taps[0] <= d;
                    for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
                end
            end

            assign q = taps[DEPTH-1];

            // cycles since reset, saturating, so the check never reads pre-reset history
            localparam int FW = $clog2(DEPTH + 1) + 1;
            logic [FW-1:0] fill;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                    fill <= '0;
                else if (fill < FW'(DEPTH))    fill <= fill + 1'b1;
            end

            assert_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (fill >= FW'(DEPTH)) |-> (q == $past(d, DEPTH)));
        end
    endgenerate
endmodule

// File: rtl/overlap_adder.sv
module overlap_adder
    import adc_corr_pkg::*;
#(
    parameter int N_FULL = 6,
    parameter int FULL_W = 3,
    parameter int LAST_W = 2,
    parameter int OUT_W  = 14,
    parameter int SUM_W  = 16
) (
    input  logic [N_FULL*FULL_W-1:0] codes,
    input  logic [LAST_W-1:0]        last,
    output logic [OUT_W-1:0]         result
);
    localparam logic [SUM_W-1:0] MAXV  = SUM_W'((1 << OUT_W) - 1);
    localparam logic [SUM_W-1:0] FLOOR =
        SUM_W'(((1 << FULL_W) - 1) << stage_shift(1, N_FULL, FULL_W, LAST_W));

    logic [SUM_W-1:0] terms [N_FULL];
    logic [SUM_W-1:0] total;

    genvar gi;
    generate
        for (gi = 0; gi < N_FULL; gi++) begin : g_term
            localparam int SH = stage_shift(gi + 1, N_FULL, FULL_W, LAST_W);
            assign terms[gi] = SUM_W'(codes[gi*FULL_W +: FULL_W]) << SH;
        end
    endgenerate

    always_comb begin
        total = SUM_W'(last);
        for (int i = 0; i < N_FULL; i++) total = total + terms[i];
    end

    always_comb begin
        if (total > MAXV) result = MAXV[OUT_W-1:0];
        else              result = total[OUT_W-1:0];
    end

    always_comb begin
        if (codes == '0 && last == '0)
            assert_zero_R4: assert (result == '0);
        if (codes[FULL_W-1:0] == '1)
            assert_floor_R4: assert (SUM_W'(result) >= FLOOR);
    end
endmodule

// File: rtl/fmt_conv.sv
module fmt_conv
    import adc_corr_pkg::*;
#(
    parameter int OUT_W = 14
) (
    input  logic [OUT_W-1:0] din,
    input  out_fmt_e         sel,
    output logic [OUT_W-1:0] dout
);
    always_comb begin
        unique case (sel)
            FMT_OFFSET: dout = din;
            FMT_TWOS:   dout = {~din[OUT_W-1], din[OUT_W-2:0]};
            default:    dout = din;
        endcase
    end
endmodule

// File: rtl/adc_pipe_corrector.sv
module adc_pipe_corrector
    import adc_corr_pkg::*;
#(
    parameter  int N_FULL = 6,
    parameter  int FULL_W = 3,
    parameter  int LAST_W = 2,
    localparam int OUT_W  = N_FULL * (FULL_W - 1) + LAST_W,
    localparam int CODE_W = N_FULL * FULL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_vld,
    input  logic [CODE_W-1:0] stage_codes,
    input  logic [LAST_W-1:0] last_code,
    input  logic              twos_fmt,
    output logic [OUT_W-1:0]  dout,
    output logic              dout_vld
);
    localparam int SUM_W = OUT_W + 2;
    localparam int LAT   = N_FULL + 2;

    logic [CODE_W-1:0] codes_al;
    logic              vld_al;
    logic [OUT_W-1:0]  sum_clamped;
    logic [OUT_W-1:0]  sum_fmt;
    out_fmt_e          fmt_sel;

    genvar gs;
    generate
        for (gs = 0; gs < N_FULL; gs++) begin : g_stage
            code_align #(.W(FULL_W), .DEPTH(N_FULL - gs)) u_align (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (stage_codes[gs*FULL_W +: FULL_W]),
                .q     (codes_al[gs*FULL_W +: FULL_W])
            );
        end
    endgenerate

    code_align #(.W(1), .DEPTH(N_FULL + 1)) u_vld_align (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sample_vld),
        .q     (vld_al)
    );

    overlap_adder #(
        .N_FULL (N_FULL),
        .FULL_W (FULL_W),
        .LAST_W (LAST_W),
        .OUT_W  (OUT_W),
        .SUM_W  (SUM_W)
    ) u_adder (
        .codes  (codes_al),
        .last   (last_code),
        .result (sum_clamped)
    );

    assign fmt_sel = twos_fmt ? FMT_TWOS : FMT_OFFSET;

    fmt_conv #(.OUT_W(OUT_W)) u_fmt (
        .din  (sum_clamped),
        .sel  (fmt_sel),
        .dout (sum_fmt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= vld_al;
            if (vld_al) dout <= sum_fmt;
        end
    end

    localparam int CW = $clog2(LAT + 1) + 1;
    logic [CW-1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  since_rst <= '0;
        else if (since_rst < CW'(LAT)) since_rst <= since_rst + 1'b1;
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= CW'(LAT)) |-> (dout_vld == $past(sample_vld, LAT)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= CW'(1) && !dout_vld) |-> $stable(dout));
endmodule

// File: tb/adc_pipe_corrector_test.sv
`timescale 1ns/1ps
module adc_pipe_corrector_test;
    localparam int NS = 120;
    localparam int NC = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_vld = 1'b0;
    logic [17:0] stage_codes = '0;
    logic [1:0]  last_code = '0;
    logic        twos_fmt = 1'b0;
    logic [13:0] dout;
    logic        dout_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int slot   [NC];
    int scode  [NS][8];
    bit sfmt   [NS];
    int unsigned seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    adc_pipe_corrector uut (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
        .stage_codes(stage_codes), .last_code(last_code),
        .twos_fmt(twos_fmt), .dout(dout), .dout_vld(dout_vld)
    );

    function automatic int rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'(seed >> 16);
    endfunction

    function automatic int expect_of(input int s);
        int v = scode[s][7];
        for (int k = 1; k <= 6; k++) v += scode[s][k] << (13 - 2*k);
        if (v > 16383) v = 16383;
        if (sfmt[s]) v = v ^ 8192;
        return v;
    endfunction

    function automatic string tag_of(input int s);
        if (s < 52)       return "R4";
        if (s < 56)       return "R5";
        if (sfmt[s])      return "R6";
        return "R3 R7";
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int last_exp;
        for (int c = 0; c < NC; c++) slot[c] = -1;
        for (int s = 0; s < NS; s++) begin
            for (int k = 0; k < 8; k++) scode[s][k] = 0;
            sfmt[s] = 0;
            if (s < 48) scode[s][s/8 + 1] = s % 8;
            else if (s < 52) scode[s][7] = s - 48;
            else if (s == 52) begin
                for (int k = 1; k <= 6; k++) scode[s][k] = 7;
                scode[s][7] = 3;
            end else if (s == 53 || s == 54) begin
                scode[s][1] = 7;
                for (int k = 2; k <= 6; k++) scode[s][k] = 3;
                scode[s][7] = (s == 53) ? 1 : 2;   // 16383 exact, then 16384
            end else if (s == 55) begin
                scode[s][1] = 7; scode[s][2] = 7;  // 17920
            end else begin
                for (int k = 1; k <= 6; k++) scode[s][k] = rnd() % 8;
                scode[s][7] = rnd() % 4;
                sfmt[s] = (s >= 60) && (s % 3 == 0);
            end
            slot[20 + s + (s/10)*3] = s;
        end

        repeat (3) @(negedge clk);
        check("R1 dout", int'(dout), 0);
        check("R1 dout_vld", int'(dout_vld), 0);
        rst_n = 1'b1;
        last_exp = 0;

        for (int c = 0; c < NC; c++) begin
            @(negedge clk);
            if (c >= 8 && slot[c-8] >= 0) begin
                check("R2 dout_vld", int'(dout_vld), 1);
                last_exp = expect_of(slot[c-8]);
                check(tag_of(slot[c-8]), int'(dout), last_exp);
            end else begin
                check("R2 dout_vld idle", int'(dout_vld), 0);
                check("R8 hold", int'(dout), last_exp);
            end
            sample_vld = (slot[c] >= 0);
            for (int k = 1; k <= 6; k++) begin
                if (c - k >= 0 && slot[c-k] >= 0)
                    stage_codes[(k-1)*3 +: 3] = 3'(scode[slot[c-k]][k]);
                else
                    stage_codes[(k-1)*3 +: 3] = 3'(rnd());
            end
            if (c - 7 >= 0 && slot[c-7] >= 0) begin
                last_code = 2'(scode[slot[c-7]][7]);
                twos_fmt  = sfmt[slot[c-7]];
            end else begin
                last_code = 2'(rnd());
                twos_fmt  = 1'(rnd());
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule